// File: doc/BRIEF.md
# Low-Power Escape Sequence Transmitter

This block produces the two-wire low-power line state of a serial data lane for escape-mode traffic. On a request it frames one escape command. First comes a fixed entry pattern. Then an 8-bit command byte follows, sent with spaced one-hot coding: every bit is a Mark state followed by a mandatory Space state. For low-power data commands, payload bytes follow the command over a valid/ready handshake. A short exit pattern then returns the lane to Stop. Each line state lasts a fixed number of clock cycles, called the symbol period.

An ultra-low-power request sends the dedicated command and then parks the lines at Space for as long as needed. A later wake request drives Mark-1 for a programmable number of cycles, sized to cover the millisecond-scale wake-up time, and then restores Stop. The output `lane` is `{p, n}`: Stop is 11, Mark-1 is 10, Mark-0 is 01 and Space is 00. The analog drivers sit outside the block.

Top module: `esc_lane_tx`

## Requirements
- R1: After synchronous reset `lane` is 11 (Stop), `busy` is 0 and `data_ready` is 0.
- R2: A request taken in idle raises `busy` on the next clock edge. `lane` then shows 11, 10, 00, 01, 00, and each state lasts SYM_CYC cycles.
- R3: After entry, the command byte goes out LSB first. Each bit is a Mark (01 for 0, 10 for 1) for SYM_CYC cycles, followed by Space (00) for SYM_CYC cycles.
- R4: When the command equals LPDT_CODE (default 8'hE1), `data_ready` is high for one cycle in the last cycle of every byte. If `data_valid` is high in that cycle, `data_byte` is sent next in the same coding; otherwise the exit follows.
- R5: For any command other than LPDT_CODE, `data_ready` stays 0 and the exit follows the command byte.
- R6: The exit drives 10 for one symbol period. `lane` then returns to 11, and `busy` falls on that same edge.
- R7: `ulp_req`, or `cmd_req` with a command equal to ULP_CODE (default 8'h1E), sends ULP_CODE. After that byte the lines stay at 00 with `busy` high until a wake request arrives.
- R8: `wake_req` in the parked state drives 10 for exactly WAKE_CYC cycles. `lane` then returns to 11 and `busy` falls.
- R9: `cmd_req` and `ulp_req` have no effect while `busy` is high. `wake_req` has no effect outside the parked state.
- R10: When `cmd_req` and `ulp_req` arrive in the same idle cycle, `cmd_req` wins and `cmd_byte` is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Start an escape frame with `cmd_byte` |
| cmd_byte | input | 8 | Escape command, sampled with `cmd_req` |
| ulp_req | input | 1 | Start an ultra-low-power entry |
| wake_req | input | 1 | Leave the parked ultra-low-power state |
| data_valid | input | 1 | Payload byte offered |
| data_byte | input | 8 | Payload byte |
| data_ready | output | 1 | Payload byte taken at this edge if valid |
| lane | output | 2 | Line state {p, n} |
| busy | output | 1 | High from entry start until Stop is restored |

## Verification
Two events can land in the same cycle. One is a new request in the final cycle of the exit symbol, the same edge on which `busy` falls. The other is `cmd_req` together with `ulp_req` in idle. Random frames keep pulsing all three request inputs while a frame runs, including in its last cycle. The bench judges this by comparing every symbol of the line sequence against a sequence it computes itself, and by checking for Stop with `busy` low one cycle after the frame ends. A directed case raises both requests at once and expects the plain command's frame, with no parked state.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTRY,
    ST_BITS,
    ST_EXIT,
    ST_HOLD,
    ST_WAKE
  } esc_st_e;

  localparam logic [1:0] LN_STOP  = 2'b11;
  localparam logic [1:0] LN_MARK1 = 2'b10;
  localparam logic [1:0] LN_MARK0 = 2'b01;
  localparam logic [1:0] LN_SPACE = 2'b00;

  localparam int unsigned ENTRY_LEN = 5;

  // line state of entry step idx
  function automatic logic [1:0] entry_line(input logic [2:0] idx);
    case (idx)
      3'd0:    entry_line = LN_STOP;
      3'd1:    entry_line = LN_MARK1;
      3'd3:    entry_line = LN_MARK0;
      default: entry_line = LN_SPACE;
    endcase
  endfunction

  function automatic logic [1:0] mark_of(input logic b);
    mark_of = b ? LN_MARK1 : LN_MARK0;
  endfunction

endpackage

// File: rtl/esc_tick_timer.sv
module esc_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt <= '0;
    else if (run)               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/esc_bit_shifter.sv
module esc_bit_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              step,
  output logic              in_space,
  output logic              nxt_bit,
  output logic              byte_done
);
  localparam int unsigned IW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shreg;
  logic [IW-1:0]     idx;

  assign nxt_bit   = shreg[1];
  assign byte_done = in_space && (idx == IW'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      idx      <= '0;
      in_space <= 1'b0;
    end else if (load) begin
      shreg    <= load_byte;
      idx      <= '0;
      in_space <= 1'b0;
    end else if (step) begin
      if (!in_space) begin
        in_space <= 1'b1;
      end else if (!byte_done) begin
        shreg    <= shreg >> 1;
        idx      <= idx + 1'b1;
        in_space <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/esc_lane_tx.sv
module esc_lane_tx
  import esc_pkg::*;
#(
  parameter int unsigned SYM_CYC   = 4,
  parameter int unsigned WAKE_CYC  = 50000,
  parameter int unsigned BYTE_W    = 8,
  parameter logic [7:0]  LPDT_CODE = 8'hE1,
  parameter logic [7:0]  ULP_CODE  = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_req,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              ulp_req,
  input  logic              wake_req,
  input  logic              data_valid,
  input  logic [BYTE_W-1:0] data_byte,
  output logic              data_ready,
  output logic [1:0]        lane,
  output logic              busy
);
  localparam logic [2:0] LAST_ENTRY = 3'(ENTRY_LEN - 1);

  esc_st_e           state;
  logic [2:0]        step;
  logic [BYTE_W-1:0] cmd_q;
  logic [1:0]        lane_q;
  logic              busy_q;

  logic sym_tick, wake_tick;
  logic in_space, nxt_bit, byte_done;
  logic accept, wake_go, is_lpdt, is_ulp, entry_done, take_data;

  assign accept     = (state == ST_IDLE) && (cmd_req || ulp_req);
  assign wake_go    = (state == ST_HOLD) && wake_req;
  assign is_lpdt    = (cmd_q == BYTE_W'(LPDT_CODE));
  assign is_ulp     = (cmd_q == BYTE_W'(ULP_CODE));
  assign entry_done = (state == ST_ENTRY) && sym_tick && (step == LAST_ENTRY);
  assign data_ready = (state == ST_BITS) && sym_tick && byte_done && is_lpdt;
  assign take_data  = data_ready && data_valid;

  esc_tick_timer #(.LIMIT(SYM_CYC)) u_sym_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     ((state == ST_ENTRY) || (state == ST_BITS) || (state == ST_EXIT)),
    .tick    (sym_tick)
  );

  esc_tick_timer #(.LIMIT(WAKE_CYC)) u_wake_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (wake_go),
    .run     (state == ST_WAKE),
    .tick    (wake_tick)
  );

  esc_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (entry_done || take_data),
    .load_byte (entry_done ? cmd_q : data_byte),
    .step      ((state == ST_BITS) && sym_tick),
    .in_space  (in_space),
    .nxt_bit   (nxt_bit),
    .byte_done (byte_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      step   <= '0;
      cmd_q  <= '0;
      lane_q <= LN_STOP;
      busy_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_ENTRY;
          step   <= '0;
          cmd_q  <= cmd_req ? cmd_byte : BYTE_W'(ULP_CODE);
          busy_q <= 1'b1;
          lane_q <= entry_line(3'd0);
        end
        ST_ENTRY: if (sym_tick) begin
          if (step == LAST_ENTRY) begin
            state  <= ST_BITS;
            lane_q <= mark_of(cmd_q[0]);
          end else begin
            step   <= step + 3'd1;
            lane_q <= entry_line(step + 3'd1);
          end
        end
        ST_BITS: if (sym_tick) begin
          if (!in_space) begin
            lane_q <= LN_SPACE;
          end else if (!byte_done) begin
            lane_q <= mark_of(nxt_bit);
          end else if (is_ulp) begin
            state  <= ST_HOLD;
            lane_q <= LN_SPACE;
          end else if (take_data) begin
            lane_q <= mark_of(data_byte[0]);
          end else begin
            state  <= ST_EXIT;
            lane_q <= LN_MARK1;
          end
        end
        ST_EXIT: if (sym_tick) begin
          state  <= ST_IDLE;
          lane_q <= LN_STOP;
          busy_q <= 1'b0;
        end
        ST_HOLD: if (wake_go) begin
          state  <= ST_WAKE;
          lane_q <= LN_MARK1;
        end
        ST_WAKE: if (wake_tick) begin
          state  <= ST_IDLE;
          lane_q <= LN_STOP;
          busy_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lane = lane_q;
  assign busy = busy_q;
endmodule

// File: rtl/esc_lane_tx_chk.sv
module esc_lane_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic [1:0] lane,
  input logic       data_ready
);
  a_r1_idle_is_stop: assert property (@(posedge clk) disable iff (rst)
    !busy |-> lane == 2'b11);

  a_r2_stop_leaves_via_mark1: assert property (@(posedge clk) disable iff (rst)
    ($past(lane) == 2'b11 && lane != 2'b11) |-> lane == 2'b10);

  a_r2_busy_rises_at_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> lane == 2'b11);

  a_r3_mark0_then_space: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(lane) == 2'b01 && lane != 2'b01) |-> lane == 2'b00);

  a_r6_busy_falls_after_mark1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (lane == 2'b11 && $past(lane) == 2'b10));

  a_r4_ready_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> busy);
endmodule

bind esc_lane_tx esc_lane_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .lane       (lane),
  .data_ready (data_ready)
);

// File: tb/tb_esc_lane_tx.sv
module tb_esc_lane_tx;
  localparam int CLK_PERIOD = 10;
  localparam int SYM  = 3;
  localparam int WAKE = 37;
  localparam logic [7:0] LPDT = 8'hE1;
  localparam logic [7:0] ULP  = 8'h1E;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_req = 1'b0, ulp_req = 1'b0, wake_req = 1'b0, data_valid = 1'b0;
  logic [7:0] cmd_byte = '0, data_byte = '0;
  logic       data_ready, busy;
  logic [1:0] lane;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [1:0] exp_sym [0:127];
  int         exp_len;
  logic [7:0] dbytes [0:3];

  always #(CLK_PERIOD/2) clk = ~clk;

  esc_lane_tx #(.SYM_CYC(SYM), .WAKE_CYC(WAKE), .BYTE_W(8),
                .LPDT_CODE(LPDT), .ULP_CODE(ULP)) dut (
    .clk(clk), .rst(rst), .cmd_req(cmd_req), .cmd_byte(cmd_byte),
    .ulp_req(ulp_req), .wake_req(wake_req), .data_valid(data_valid),
    .data_byte(data_byte), .data_ready(data_ready), .lane(lane), .busy(busy));

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [1:0] s);
    exp_sym[exp_len] = s;
    exp_len++;
  endfunction

  function automatic void push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      push(b[i] ? 2'b10 : 2'b01);
      push(2'b00);
    end
  endfunction

  // expected line symbols of a frame carrying command c and n payload bytes
  function automatic void build(input logic [7:0] c, input int n);
    exp_len = 0;
    push(2'b11); push(2'b10); push(2'b00); push(2'b01); push(2'b00);
    push_byte(c);
    if (c == LPDT)
      for (int k = 0; k < n; k++) push_byte(dbytes[k]);
    if (c != ULP) push(2'b10);
  endfunction

  function automatic string sym_req(input int j, input bit ends_exit);
    if (j < 5)  return "R2";
    if (j < 21) return "R3";
    if (ends_exit && j == exp_len - 1) return "R6";
    return "R4";
  endfunction

  // drives one frame and compares every symbol; noise pulses requests meanwhile
  task automatic run_frame(input logic [7:0] c, input int n, input bit use_ulp,
                           input bit both, input bit noise);
    logic [7:0] sent;
    int  k = 0;
    int  hs = 0;
    bit  pend = 0;
    sent = use_ulp ? ULP : c;
    build(sent, n);
    @(negedge clk);
    cmd_byte   = c;
    cmd_req    = !use_ulp || both;
    ulp_req    = use_ulp || both;
    data_valid = (n > 0);
    data_byte  = dbytes[0];
    @(negedge clk);
    cmd_req = 0; ulp_req = 0;
    for (int j = 0; j < exp_len; j++) begin
      bit ok = 1;
      int act = 0;
      for (int s = 0; s < SYM; s++) begin
        if (j > 0 || s > 0) @(negedge clk);
        if (pend) begin
          k++;
          pend = 0;
          data_valid = (k < n);
          data_byte  = dbytes[k < 4 ? k : 3];
        end
        if (lane != exp_sym[j] || !busy) begin ok = 0; act = {busy, lane}; end
        if (data_ready && data_valid) begin hs++; pend = 1; end
        if (noise) begin
          cmd_req  = ($urandom % 5) == 0;
          ulp_req  = ($urandom % 5) == 0;
          wake_req = ($urandom % 5) == 0;
        end
      end
      chk(ok, sym_req(j, sent != ULP), "symbol {busy,lane}", act, {1'b1, exp_sym[j]});
    end
    if (sent == LPDT) chk(hs == n, "R4", "payload handshakes", hs, n);
    else              chk(hs == 0, "R5", "payload handshakes", hs, 0);
    if (sent != ULP) begin
      @(negedge clk);
      cmd_req = 0; ulp_req = 0; wake_req = 0; data_valid = 0;
      chk(!busy && lane == 2'b11, both ? "R10" : "R9", "stop after exit {busy,lane}",
          {busy, lane}, 3'b011);
    end
    cmd_req = 0; ulp_req = 0; wake_req = 0; data_valid = 0;
  endtask

  task automatic park_and_wake();
    bit ok = 1;
    cmd_req = 1;
    cmd_byte = 8'h33;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lane != 2'b00 || !busy) ok = 0;
    end
    cmd_req = 0;
    chk(ok, "R7", "parked at space, request ignored (R9)", lane, 0);
    @(negedge clk);
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    ok = 1;
    for (int i = 0; i < WAKE; i++) begin
      if (i > 0) @(negedge clk);
      if (lane != 2'b10 || !busy) ok = 0;
    end
    chk(ok, "R8", "mark-1 held for wake time", lane, 2);
    @(negedge clk);
    chk(!busy && lane == 2'b11, "R8", "stop after wake {busy,lane}", {busy, lane}, 3'b011);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(lane == 2'b11 && !busy && !data_ready, "R1", "reset state",
        {data_ready, busy, lane}, 4'b0011);

    // wake request while idle has no effect
    wake_req = 1;
    repeat (4) @(negedge clk);
    wake_req = 0;
    chk(lane == 2'b11 && !busy, "R9", "wake while idle ignored", {busy, lane}, 3'b011);

    // directed: payload with extreme patterns
    dbytes[0] = 8'h00; dbytes[1] = 8'hFF; dbytes[2] = 8'hA5; dbytes[3] = 8'h5A;
    run_frame(LPDT, 2, 0, 0, 0);
    // LPDT command with no payload offered
    run_frame(LPDT, 0, 0, 0, 0);
    // non-LPDT command with data offered: ignored (R5)
    run_frame(8'h00, 2, 0, 0, 0);
    // both requests in the same idle cycle (R10)
    run_frame(8'h5A, 0, 0, 1, 0);

    // ultra-low-power via dedicated request, then wake
    run_frame(8'h00, 0, 1, 0, 0);
    park_and_wake();
    // ultra-low-power via the command path (R7)
    run_frame(ULP, 0, 0, 0, 0);
    park_and_wake();

    // random frames with request noise while busy
    for (int t = 0; t < 14; t++) begin
      logic [7:0] c;
      int n;
      c = (($urandom % 3) == 0) ? LPDT : 8'($urandom);
      if (c == ULP) c = c ^ 8'h01;
      n = $urandom % 4;
      for (int k = 0; k < 4; k++) dbytes[k] = 8'($urandom);
      run_frame(c, n, 0, 0, 1);
    end

    summary();
    $finish;
  end
endmodule